// File: doc/BRIEF.md
# Narrowing Shift-and-Clip Unit

This block turns one group of wide vector elements into a group of SEW-wide elements per cycle. Each source element is either twice or four times SEW wide. It is shifted right by an amount that comes from one of three places: a per-element vector operand, one scalar shared by all lanes, or a 5-bit immediate.

Four operations are offered:
- a logical narrowing shift;
- an arithmetic narrowing shift;
- a signed clip;
- an unsigned clip.

The two clip operations round the bits that are shifted out. The rounding is set by a 2-bit mode: round-up, nearest-even, truncate or jam. The clipped result then saturates to the destination range.

A 2-bit mask control, together with one mask bit per lane, decides which lanes are written. A lane that is not written passes its old destination value through unchanged and reports a write enable of zero. Fetching the operands and laying out register groups are handled outside the block.

Top module: `nrw_clip_unit`

## Requirements
- R1: Operation code 00 (logical shift) shifts the source right, fills with zeros and returns the low SEW bits, with no rounding and no saturation.
- R2: Operation code 01 (arithmetic shift) shifts the source, treated as signed, right, fills with the sign bit and returns the low SEW bits, with no rounding and no saturation.
- R3: Operation code 10 (signed clip) rounds the signed shifted value and then saturates it to the range -2^(SEW-1) to 2^(SEW-1)-1.
- R4: Operation code 11 (unsigned clip) treats the source as signed, rounds it and saturates it to the range 0 to 2^SEW-1. Any negative source gives 0.
- R5: Rounding mode 00 (round-up) adds one half of a destination LSB before the shifted-out bits are discarded.
- R6: Rounding mode 01 (nearest-even) rounds to the nearer value. On an exact half it picks the value whose LSB is 0.
- R7: Rounding mode 10 (truncate) discards the shifted-out bits. For the clips this equals a floor of the signed value.
- R8: Rounding mode 11 (jam) ORs into the result LSB a 1 if any shifted-out bit is nonzero.
- R9: The shift amount is taken as follows:
  - Operand select 00 takes each lane's own amount, 01 takes the shared scalar, and 1x takes the 5-bit immediate, read as unsigned.
  - Only the low log2(source width) bits of the chosen amount are used.
- R10: Mask control sets which lanes are enabled:
  - 00 enables lanes whose mask bit is 0;
  - 01 enables lanes whose mask bit is 1;
  - 10 enables lane 0 only;
  - 11 enables every lane.

  A disabled lane outputs its old destination value with write enable 0.
- R11: Results appear exactly one clock after an input marked valid, and out_valid follows in_valid with that same delay. After reset, and in any cycle without a result, out_valid and out_wen are 0.
- R12: With in_quad=0 the source is the low 2·SEW bits of each lane's field. The upper half of the field has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Input group valid |
| in_op | input | 2 | 00 logical shift, 01 arithmetic shift, 10 signed clip, 11 unsigned clip |
| in_quad | input | 1 | 1: source is 4·SEW wide, 0: source is 2·SEW wide |
| in_opnd | input | 2 | Shift source: 00 vector, 01 scalar, 1x immediate |
| in_rmode | input | 2 | Rounding mode for the clips: 00 up, 01 nearest-even, 10 truncate, 11 jam |
| in_mctl | input | 2 | Mask control: 00 mask bit 0, 01 mask bit 1, 10 lane 0 only, 11 all lanes |
| in_src | input | LANES·4·SEW | Source element fields, lane 0 in the low bits |
| in_vshamt | input | LANES·SEW | Per-lane shift amounts |
| in_sshamt | input | SEW | Shared scalar shift amount |
| in_imm | input | 5 | Immediate shift amount |
| in_vmask | input | LANES | Mask bit per lane |
| in_dold | input | LANES·SEW | Old destination values |
| out_valid | output | 1 | Result group valid |
| out_wen | output | LANES | Per-lane write enable |
| out_data | output | LANES·SEW | Result elements, old value on disabled lanes |

## Verification
Every result, write enable and valid bit is due one rising edge after the input is presented. The bench drives each group on a falling edge and compares all outputs on the next falling edge, so every comparison sits exactly one register after its stimulus. At that same sample the bench drops in_valid, which lets it check the idle outputs one cycle later. Expected lane values come from an integer model that applies floor division and range clamping, not bit slicing. Directed vectors cover halves, jam bits, saturation at both ends, negative unsigned clips, oversized shift amounts and junk in the upper halves of the source fields.

// File: rtl/nrw_pkg.sv
package nrw_pkg;

   typedef enum logic [1:0] {
      NRW_SRL   = 2'b00,
      NRW_SRA   = 2'b01,
      NRW_CLIPS = 2'b10,
      NRW_CLIPU = 2'b11
   } nrw_op_e;

   typedef enum logic [1:0] {
      RND_UP    = 2'b00,
      RND_EVEN  = 2'b01,
      RND_TRUNC = 2'b10,
      RND_JAM   = 2'b11
   } nrw_rnd_e;

   typedef enum logic [1:0] {
      MSK_ZERO  = 2'b00,
      MSK_ONE   = 2'b01,
      MSK_ELEM0 = 2'b10,
      MSK_ALL   = 2'b11
   } nrw_mctl_e;

   localparam int IMM_W = 5;

endpackage

// File: rtl/nrw_round.sv
// Rounding decision on the bits discarded by a right shift.
module nrw_round #(
   parameter int W    = 32,
   parameter int SH_W = 5
) (
   input  logic [W-1:0]    x,
   input  logic [SH_W-1:0] sh,
   input  logic            q_lsb,
   input  logic [1:0]      rmode,
   input  logic            en,
   output logic            inc,
   output logic            jam_set
);
   import nrw_pkg::*;

   logic [W-1:0]    out_mask;
   logic [W-1:0]    low_mask;
   logic [W-1:0]    guard_vec;
   logic [SH_W-1:0] sh_m1;
   logic            nz_sh;
   logic            guard;
   logic            sticky;
   logic            any_out;
   nrw_rnd_e        mode;

   always_comb begin
      mode      = nrw_rnd_e'(rmode);
      nz_sh     = (sh != '0);
      sh_m1     = sh - SH_W'(1);
      out_mask  = (W'(1) << sh) - W'(1);
      low_mask  = (W'(1) << sh_m1) - W'(1);
      guard_vec = x >> sh_m1;
      guard     = nz_sh & guard_vec[0];
      sticky    = nz_sh & (|(x & low_mask));
      any_out   = |(x & out_mask);
      inc       = 1'b0;
      jam_set   = 1'b0;
      if (en) begin
         unique case (mode)
            RND_UP:    inc     = guard;
            RND_EVEN:  inc     = guard & (sticky | q_lsb);
            RND_TRUNC: inc     = 1'b0;
            RND_JAM:   jam_set = any_out;
            default:   inc     = 1'b0;
         endcase
      end
   end

endmodule

// File: rtl/nrw_sat.sv
// Range clamp from the wide intermediate to SEW bits.
module nrw_sat #(
   parameter int SEW = 8,
   parameter int W   = 32
) (
   input  logic [W-1:0]   val,
   input  logic           sat_en,
   input  logic           uns,
   output logic [SEW-1:0] res
);
   localparam logic [SEW-1:0] SMAX = {1'b0, {(SEW-1){1'b1}}};
   localparam logic [SEW-1:0] SMIN = {1'b1, {(SEW-1){1'b0}}};

   logic [W-SEW:0] top_s;
   logic [W-SEW-1:0] top_u;
   logic s_fit;
   logic u_big;

   always_comb begin
      top_s = val[W-1:SEW-1];
      top_u = val[W-1:SEW];
      s_fit = (&top_s) | (~|top_s);
      u_big = |top_u;
      res   = val[SEW-1:0];
      if (sat_en) begin
         if (uns) begin
            if (val[W-1])  res = '0;
            else if (u_big) res = '1;
         end else if (!s_fit) begin
            res = val[W-1] ? SMIN : SMAX;
         end
      end
   end

endmodule

// File: rtl/nrw_lane.sv
// One lane: widen, shift, round, clamp.
module nrw_lane #(
   parameter int SEW = 8
) (
   input  logic [1:0]               op,
   input  logic                     quad,
   input  logic [1:0]               rmode,
   input  logic [4*SEW-1:0]         src,
   input  logic [$clog2(4*SEW)-1:0] shamt,
   output logic [SEW-1:0]           res
);
   import nrw_pkg::*;

   localparam int W    = 4 * SEW;
   localparam int HW   = 2 * SEW;
   localparam int SH_W = $clog2(W);

   nrw_op_e         opc;
   logic            sgn_op;
   logic            clip_op;
   logic [W-1:0]    x;
   logic [SH_W-1:0] eff_sh;
   logic [W-1:0]    shifted;
   logic [W-1:0]    rounded;
   logic            inc;
   logic            jam_set;

   always_comb begin
      opc     = nrw_op_e'(op);
      sgn_op  = (opc != NRW_SRL);
      clip_op = (opc == NRW_CLIPS) || (opc == NRW_CLIPU);
      if (quad) begin
         x      = src;
         eff_sh = shamt;
      end else begin
         x      = {{HW{sgn_op & src[HW-1]}}, src[HW-1:0]};
         eff_sh = {1'b0, shamt[SH_W-2:0]};
      end
      if (sgn_op) shifted = W'($signed(x) >>> eff_sh);
      else        shifted = x >> eff_sh;
   end

   nrw_round #(.W(W), .SH_W(SH_W)) i_round (
      .x       (x),
      .sh      (eff_sh),
      .q_lsb   (shifted[0]),
      .rmode   (rmode),
      .en      (clip_op),
      .inc     (inc),
      .jam_set (jam_set)
   );

   always_comb begin
      rounded    = shifted + W'(inc);
      rounded[0] = rounded[0] | jam_set;
   end

   nrw_sat #(.SEW(SEW), .W(W)) i_sat (
      .val    (rounded),
      .sat_en (clip_op),
      .uns    (opc == NRW_CLIPU),
      .res    (res)
   );

   // R4: a negative source can never leave the unsigned clip as nonzero
   always_comb begin
      if (!$isunknown({op, quad, src, shamt, rmode}) &&
          (opc == NRW_CLIPU) && x[W-1]) begin
         a_r4_neg_clamps_zero: assert (res == '0)
            else $error("unsigned clip of negative source gave nonzero");
      end
   end

endmodule

// File: rtl/nrw_enable.sv
// Per-lane enable decode from mask control and mask bits.
module nrw_enable #(
   parameter int LANES = 4
) (
   input  logic [1:0]       mctl,
   input  logic [LANES-1:0] vmask,
   output logic [LANES-1:0] en
);
   import nrw_pkg::*;

   nrw_mctl_e mode;
   assign mode = nrw_mctl_e'(mctl);

   for (genvar i = 0; i < LANES; i++) begin : g_en
      always_comb begin
         unique case (mode)
            MSK_ZERO:  en[i] = ~vmask[i];
            MSK_ONE:   en[i] = vmask[i];
            MSK_ELEM0: en[i] = (i == 0);
            MSK_ALL:   en[i] = 1'b1;
            default:   en[i] = 1'b0;
         endcase
      end
   end

endmodule

// File: rtl/nrw_clip_unit.sv
module nrw_clip_unit #(
   parameter int SEW     = 8,
   parameter int LANES   = 4,
   parameter bit REG_OUT = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 in_valid,
   input  logic [1:0]           in_op,
   input  logic                 in_quad,
   input  logic [1:0]           in_opnd,
   input  logic [1:0]           in_rmode,
   input  logic [1:0]           in_mctl,
   input  logic [LANES*4*SEW-1:0] in_src,
   input  logic [LANES*SEW-1:0] in_vshamt,
   input  logic [SEW-1:0]       in_sshamt,
   input  logic [4:0]           in_imm,
   input  logic [LANES-1:0]     in_vmask,
   input  logic [LANES*SEW-1:0] in_dold,
   output logic                 out_valid,
   output logic [LANES-1:0]     out_wen,
   output logic [LANES*SEW-1:0] out_data
);
   import nrw_pkg::*;

   localparam int W    = 4 * SEW;
   localparam int SH_W = $clog2(W);

   if (SEW < 8 || (SEW & (SEW - 1)) != 0) begin : g_bad_sew
      $error("SEW must be a power of two and at least 8");
   end
   if (LANES < 1) begin : g_bad_lanes
      $error("LANES must be at least 1");
   end

   logic [LANES-1:0]     en;
   logic [LANES*SEW-1:0] merged;
   logic [SEW-1:0]       imm_ext;

   assign imm_ext = {{(SEW-IMM_W){1'b0}}, in_imm};

   nrw_enable #(.LANES(LANES)) i_enable (
      .mctl  (in_mctl),
      .vmask (in_vmask),
      .en    (en)
   );

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      logic [SEW-1:0] sh_full;
      logic [SEW-1:0] lane_res;

      always_comb begin
         if (in_opnd[1])      sh_full = imm_ext;
         else if (in_opnd[0]) sh_full = in_sshamt;
         else                 sh_full = in_vshamt[i*SEW +: SEW];
      end

      nrw_lane #(.SEW(SEW)) i_lane (
         .op    (in_op),
         .quad  (in_quad),
         .rmode (in_rmode),
         .src   (in_src[i*W +: W]),
         .shamt (sh_full[SH_W-1:0]),
         .res   (lane_res)
      );

      assign merged[i*SEW +: SEW] = en[i] ? lane_res : in_dold[i*SEW +: SEW];
   end

   if (REG_OUT) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            out_valid <= 1'b0;
            out_wen   <= '0;
            out_data  <= '0;
         end else begin
            out_valid <= in_valid;
            out_wen   <= in_valid ? en : '0;
            if (in_valid) out_data <= merged;
         end
      end

      // R11: valid is carried with one cycle of delay
      a_r11_valid_delay: assert property (@(posedge clk) disable iff (!rst_n)
         in_valid |=> out_valid);
      a_r11_idle_delay: assert property (@(posedge clk) disable iff (!rst_n)
         !in_valid |=> !out_valid);
      // R11: no write enable without a result
      a_r11_no_wen_idle: assert property (@(posedge clk) disable iff (!rst_n)
         !out_valid |-> (out_wen == '0));
      // R10: lane-0-only mode never writes two lanes
      a_r10_elem0_single: assert property (@(posedge clk) disable iff (!rst_n)
         (out_valid && $past(in_mctl) == 2'b10) |-> $onehot0(out_wen));

      for (genvar j = 0; j < LANES; j++) begin : g_chk
         // R10: a disabled lane carries the old destination value
         a_r10_disabled_keeps: assert property (@(posedge clk) disable iff (!rst_n)
            (out_valid && !out_wen[j]) |->
               (out_data[j*SEW +: SEW] == $past(in_dold[j*SEW +: SEW])));
      end
   end else begin : g_comb
      assign out_valid = in_valid;
      assign out_wen   = in_valid ? en : '0;
      assign out_data  = merged;
   end

endmodule

// File: tb/test_nrw_clip_unit.sv
module test_nrw_clip_unit;

   localparam int  SEW      = 8;
   localparam int  LANES    = 4;
   localparam int  W        = 4 * SEW;
   localparam time CLK_PER  = 10ns;
   localparam int  WD_LIMIT = 100000;

   logic                   clk = 1'b0;
   logic                   rst_n;
   logic                   in_valid;
   logic [1:0]             in_op;
   logic                   in_quad;
   logic [1:0]             in_opnd;
   logic [1:0]             in_rmode;
   logic [1:0]             in_mctl;
   logic [LANES*W-1:0]     in_src;
   logic [LANES*SEW-1:0]   in_vshamt;
   logic [SEW-1:0]         in_sshamt;
   logic [4:0]             in_imm;
   logic [LANES-1:0]       in_vmask;
   logic [LANES*SEW-1:0]   in_dold;
   logic                   out_valid;
   logic [LANES-1:0]       out_wen;
   logic [LANES*SEW-1:0]   out_data;

   int n_checks = 0;
   int n_fails  = 0;
   int cycles   = 0;

   always #(CLK_PER/2) clk = ~clk;

   nrw_clip_unit #(.SEW(SEW), .LANES(LANES)) i_nrw_clip_unit (
      .clk, .rst_n, .in_valid, .in_op, .in_quad, .in_opnd, .in_rmode,
      .in_mctl, .in_src, .in_vshamt, .in_sshamt, .in_imm, .in_vmask,
      .in_dold, .out_valid, .out_wen, .out_data
   );

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures",
               n_checks, n_fails);
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > WD_LIMIT) begin
         n_checks++;
         n_fails++;
         $display("FAIL watchdog: run hung, actual %0d cycles expected < %0d",
                  cycles, WD_LIMIT);
         summary();
         $finish;
      end
   end

   task automatic check(string req, string what, longint act, longint exp);
      n_checks++;
      if (act != exp) begin
         n_fails++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
      end
   endtask

   // Integer model of one lane (R1..R9, R12)
   function automatic logic [7:0] ref_lane(logic [1:0] op, logic quad,
                                           logic [1:0] rm, logic [31:0] src,
                                           int sh_raw);
      int     srcw;
      int     sh;
      longint ux, sx, q, rem, half, r;
      srcw = quad ? 32 : 16;
      sh   = sh_raw % srcw;
      ux   = quad ? longint'(src) : longint'(src[15:0]);
      sx   = quad ? longint'($signed(src)) : longint'($signed(src[15:0]));
      if (op == 2'b00) begin
         r = ux >> sh;
         return r[7:0];
      end
      q = sx >>> sh;
      if (op == 2'b01) return q[7:0];
      rem  = sx - (q <<< sh);
      half = (sh > 0) ? (64'sd1 <<< (sh - 1)) : 0;
      r    = q;
      case (rm)
         2'b00: if (sh > 0 && rem >= half) r = q + 1;
         2'b01: if (sh > 0 && (rem > half || (rem == half && q[0]))) r = q + 1;
         2'b11: if (rem != 0) r = q | 1;
         default: r = q;
      endcase
      if (op == 2'b10) begin
         if (r > 127)  r = 127;
         if (r < -128) r = -128;
      end else begin
         if (r < 0)   r = 0;
         if (r > 255) r = 255;
      end
      return r[7:0];
   endfunction

   function automatic string op_req(logic [1:0] op);
      case (op)
         2'b00:   return "R1";
         2'b01:   return "R2";
         2'b10:   return "R3";
         default: return "R4";
      endcase
   endfunction

   // Drive at a falling edge, compare one clock later at the next falling edge.
   task automatic apply(string req);
      logic [LANES-1:0] exp_wen;
      logic [7:0]       exp_d;
      int               sh;
      for (int i = 0; i < LANES; i++) begin
         case (in_mctl)
            2'b00:   exp_wen[i] = ~in_vmask[i];
            2'b01:   exp_wen[i] = in_vmask[i];
            2'b10:   exp_wen[i] = (i == 0);
            default: exp_wen[i] = 1'b1;
         endcase
      end
      in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      check("R11", "out_valid", out_valid, 1);
      check("R10", "out_wen", out_wen, exp_wen);
      for (int i = 0; i < LANES; i++) begin
         if (in_opnd[1])      sh = in_imm;
         else if (in_opnd[0]) sh = in_sshamt;
         else                 sh = in_vshamt[i*SEW +: SEW];
         exp_d = exp_wen[i] ? ref_lane(in_op, in_quad, in_rmode, in_src[i*W +: W], sh)
                            : in_dold[i*SEW +: SEW];
         check(exp_wen[i] ? req : "R10", $sformatf("lane %0d data", i),
               out_data[i*SEW +: SEW], exp_d);
      end
   endtask

   task automatic set_all(logic [1:0] op, logic quad, logic [1:0] opnd,
                          logic [1:0] rm, logic [31:0] s, logic [7:0] sh);
      in_op = op; in_quad = quad; in_opnd = opnd; in_rmode = rm;
      in_mctl = 2'b11; in_sshamt = sh; in_imm = sh[4:0];
      for (int i = 0; i < LANES; i++) begin
         in_src[i*W +: W]        = s;
         in_vshamt[i*SEW +: SEW] = sh;
      end
   endtask

   initial begin
      void'($urandom(32'd20240611));
      rst_n = 1'b0; in_valid = 1'b0; in_op = '0; in_quad = 1'b0; in_opnd = '0;
      in_rmode = '0; in_mctl = 2'b11; in_src = '0; in_vshamt = '0;
      in_sshamt = '0; in_imm = '0; in_vmask = '0; in_dold = 32'hA5A5_A5A5;
      repeat (3) @(negedge clk);
      check("R11", "reset out_valid", out_valid, 0);
      check("R11", "reset out_wen", out_wen, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R11", "idle out_valid", out_valid, 0);

      // R5/R6/R7/R8: halves and sticky bits at shift 2, double width
      for (int rm = 0; rm < 4; rm++) begin
         set_all(2'b10, 1'b0, 2'b00, rm[1:0], 32'h0000_0006, 8'd2); apply(rm == 0 ? "R5" : rm == 1 ? "R6" : rm == 2 ? "R7" : "R8");
         set_all(2'b10, 1'b0, 2'b00, rm[1:0], 32'h0000_000A, 8'd2); apply(rm == 1 ? "R6" : "R5");
         set_all(2'b10, 1'b0, 2'b00, rm[1:0], 32'h0000_0009, 8'd2); apply(rm == 3 ? "R8" : "R7");
         set_all(2'b10, 1'b0, 2'b00, rm[1:0], 32'h0000_FFF6, 8'd2); apply(rm == 1 ? "R6" : "R7");
      end
      // R3: saturation at both ends
      set_all(2'b10, 1'b1, 2'b01, 2'b10, 32'h0001_0000, 8'd4);  apply("R3");
      set_all(2'b10, 1'b1, 2'b01, 2'b10, 32'hFFF0_0000, 8'd4);  apply("R3");
      set_all(2'b10, 1'b0, 2'b00, 2'b00, 32'h0000_00FF, 8'd1);  apply("R3");
      // R4: negative clamps to zero, large clamps to all ones
      set_all(2'b11, 1'b0, 2'b00, 2'b00, 32'h0000_8001, 8'd3);  apply("R4");
      set_all(2'b11, 1'b1, 2'b00, 2'b11, 32'h0000_4000, 8'd2);  apply("R4");
      // R1/R2: zero fill versus sign fill
      set_all(2'b00, 1'b1, 2'b00, 2'b00, 32'hF000_0000, 8'd24); apply("R1");
      set_all(2'b01, 1'b1, 2'b00, 2'b00, 32'hF000_0000, 8'd24); apply("R2");
      // R9: oversize amounts keep only the low bits; immediate read unsigned
      set_all(2'b00, 1'b1, 2'b01, 2'b00, 32'h1234_5678, 8'd37); apply("R9");
      set_all(2'b01, 1'b0, 2'b10, 2'b00, 32'h0000_8F00, 8'd20); apply("R9");
      // R12: junk in upper half of a double-width field
      set_all(2'b10, 1'b0, 2'b00, 2'b01, 32'hDEAD_0123, 8'd3);  apply("R12");
      // R10: every mask mode
      for (int m = 0; m < 4; m++) begin
         set_all(2'b01, 1'b0, 2'b00, 2'b00, 32'h0000_7F00, 8'd8);
         in_mctl = m[1:0]; in_vmask = 4'b0110; in_dold = 32'h1122_3344;
         apply("R10");
      end
      @(negedge clk);
      check("R11", "out_valid after idle", out_valid, 0);
      check("R11", "out_wen after idle", out_wen, 0);

      // Constrained random traffic
      for (int n = 0; n < 400; n++) begin
         in_op     = 2'($urandom());
         in_quad   = 1'($urandom());
         in_opnd   = 2'($urandom());
         in_rmode  = 2'($urandom());
         in_mctl   = ($urandom_range(0, 3) == 0) ? 2'b11 : 2'($urandom());
         in_src    = {$urandom(), $urandom(), $urandom(), $urandom()};
         in_vshamt = $urandom();
         in_sshamt = 8'($urandom());
         in_imm    = 5'($urandom());
         in_vmask  = 4'($urandom());
         in_dold   = $urandom();
         apply(op_req(in_op));
      end

      summary();
      $finish;
   end

endmodule